// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches eight external interrupt request pins and produces one request line per pin. Each pin has a two-bit sense code. The code selects one of four detection modes: active-low level, falling edge, rising edge, or both edges. All pin inputs are first resynchronized to the block clock. The detector for each pin then compares the newest synchronized sample with the one before it.

Software reaches three registers through a small register bus:
- a 16-bit sense-code register,
- a per-pin event flag register, cleared by writing 1,
- a per-pin request enable register.

An edge-mode detection sets a sticky flag, which drives the request while the pin is enabled. In level mode the request simply follows the synchronized low level, and no flag is latched. Writing a new code for a pin discards that pin's pending flag and its edge history, so switching modes cannot fake an event.

A synchronous reset clears the register state. Hardware standby has the same clearing effect and holds it for as long as it is asserted. At all other times, including any low-power state that does not drive those two inputs, the registers keep their contents.

Top module: `irq_sense_unit`

## Requirements
- R1: The sense-code register sits at bus address 0 and all 16 bits read back as written. Pin i uses bits 2i+1 (upper, B) and 2i (lower, A), so pin 7 owns bits 15:14 and pin 0 owns bits 1:0.
- R2: With code B:A = 00, irq_req[i] is high while the enabled pin is low. It follows a pin change on the second rising clock edge after the change, and no flag is set.
- R3: With code 01, a high-to-low pin transition sets flag i on the third rising clock edge after the change. A low-to-high transition sets nothing.
- R4: With code 10, a low-to-high transition sets flag i with the same latency. A high-to-low transition sets nothing.
- R5: With code 11, transitions in either direction set flag i.
- R6: Flags read at bus address 1, with pin i at bit i, and stay set until a bus write to address 1 carries 1 in bit i. Writing 0 bits leaves flags alone. If a new event for pin i arrives in the same cycle as its clear, the flag stays set.
- R7: The enable register sits at bus address 2, with pin i at bit i, and reads back as written. A disabled pin drives irq_req low, but its flag still records events.
- R8: While rst or hw_stby is high, the sense codes, the flags and the enables go to zero and bus writes are ignored. After release, all registers read 0.
- R9: A write to address 0 that changes pin i's code clears flag i. It also ignores any pin transition that is still being evaluated in the cycle right after the write.
- R10: In an edge mode, irq_req[i] equals flag i AND enable i, and it updates in the same cycle that the flag or the enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby; clears and holds register state like reset |
| irq_pin | input | 8 | Asynchronous external interrupt request pins |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Access is a write when high, a read when low |
| bus_addr | input | 2 | Register select: 0 sense codes, 1 flags, 2 enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not selected) |
| irq_req | output | 8 | Per-pin interrupt request |

## Verification
The bench places opposite modes on pin 7 and pin 0 and drives every pin in one step. A design with swapped or mirrored fields would flag the wrong pin or flag no pin at all. Each edge mode is checked against both directions at the exact cycle a flag first appears. A detector wired to the wrong polarity, or with one synchronizer stage too many or too few, would be caught one cycle early or late.

Two races are aimed for directly:
- A flag clear written in the same cycle as a new event. A design that lets the clear win would lose the event.
- A sense-code change written while a transition is still inside the detector. A design that keeps stale history would raise a false flag.

Hardware standby is pulsed together with a write. A design that cleared only on reset, or that accepted writes during standby, would read back non-zero values.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    localparam int SENSE_W    = 2;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CODES  = 2'd0,
        REG_EVENTS = 2'd1,
        REG_ENABLE = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        sense_e mode;
        logic   enable;
        logic   clr;
        logic   chg;
    } pin_ctl_t;

    function automatic logic is_edge_mode(input sense_e m);
        return m != SENSE_LOW;
    endfunction

    function automatic logic sense_hit(input sense_e m, input logic cur, input logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        case (m)
            SENSE_FALL: return fall;
            SENSE_RISE: return rise;
            SENSE_BOTH: return rise | fall;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
    parameter int   WIDTH     = 8,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (clr) begin
            stg <= {(STAGES*WIDTH){RESET_VAL}};
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                                clk,
    input  logic                                clr_all,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [REG_ADDR_W-1:0]               bus_addr,
    input  logic [SENSE_W*NUM_PINS-1:0]         bus_wdata,
    input  logic [NUM_PINS-1:0]                 flags,
    output logic [SENSE_W*NUM_PINS-1:0]         bus_rdata,
    output pin_ctl_t [NUM_PINS-1:0]             ctl,
    output logic [SENSE_W*NUM_PINS-1:0]         codes_q,
    output logic [NUM_PINS-1:0]                 ena_q
);

    localparam int DATA_W = SENSE_W * NUM_PINS;

    reg_sel_e sel;
    logic     wr_codes;
    logic     wr_events;
    logic     wr_enable;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_codes  = bus_sel & bus_wr & (sel == REG_CODES);
    assign wr_events = bus_sel & bus_wr & (sel == REG_EVENTS);
    assign wr_enable = bus_sel & bus_wr & (sel == REG_ENABLE);

    always_ff @(posedge clk) begin
        if (clr_all) begin
            codes_q <= '0;
            ena_q   <= '0;
        end else begin
            if (wr_codes) begin
                codes_q <= bus_wdata;
            end
            if (wr_enable) begin
                ena_q <= bus_wdata[NUM_PINS-1:0];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            ctl[i].mode   = sense_e'(codes_q[SENSE_W*i +: SENSE_W]);
            ctl[i].enable = ena_q[i];
            ctl[i].clr    = wr_events & bus_wdata[i];
            ctl[i].chg    = wr_codes &
                            (bus_wdata[SENSE_W*i +: SENSE_W] != codes_q[SENSE_W*i +: SENSE_W]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel)
                REG_CODES:  bus_rdata = codes_q;
                REG_EVENTS: bus_rdata[NUM_PINS-1:0] = flags;
                REG_ENABLE: bus_rdata[NUM_PINS-1:0] = ena_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    logic [DATA_W-1:0] unused_width_probe;
    assign unused_width_probe = '0;

endmodule

// File: rtl/irq_sense_detect.sv
module irq_sense_detect
    import irq_sense_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     pin_s,
    input  pin_ctl_t ctl,
    output logic     flag,
    output logic     req
);

    logic prev_q;
    logic armed_q;
    logic event_hit;

    assign event_hit = armed_q & is_edge_mode(ctl.mode) & sense_hit(ctl.mode, pin_s, prev_q);

    always_ff @(posedge clk) begin
        if (clr) begin
            prev_q  <= IDLE_LEVEL;
            armed_q <= 1'b0;
            flag    <= 1'b0;
        end else begin
            prev_q  <= pin_s;
            armed_q <= ~ctl.chg;
            if (ctl.chg) begin
                flag <= 1'b0;
            end else if (event_hit) begin
                flag <= 1'b1;
            end else if (ctl.clr) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        if (ctl.mode == SENSE_LOW) begin
            req = ctl.enable & ~pin_s;
        end else begin
            req = ctl.enable & flag;
        end
    end

endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hw_stby,
    input  logic [NUM_PINS-1:0]         irq_pin,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [REG_ADDR_W-1:0]       bus_addr,
    input  logic [SENSE_W*NUM_PINS-1:0] bus_wdata,
    output logic [SENSE_W*NUM_PINS-1:0] bus_rdata,
    output logic [NUM_PINS-1:0]         irq_req
);

    localparam int   DATA_W     = SENSE_W * NUM_PINS;
    localparam logic IDLE_LEVEL = 1'b1;

    logic                  clr_all;
    logic [NUM_PINS-1:0]   pin_s;
    logic [NUM_PINS-1:0]   flags;
    logic [DATA_W-1:0]     codes_q;
    logic [NUM_PINS-1:0]   ena_q;
    logic [NUM_PINS-1:0]   clr_vec;
    logic [NUM_PINS-1:0]   chg_vec;
    pin_ctl_t [NUM_PINS-1:0] ctl;

    assign clr_all = rst | hw_stby;

    irq_sense_sync #(
        .WIDTH     (NUM_PINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk (clk),
        .clr (clr_all),
        .d   (irq_pin),
        .q   (pin_s)
    );

    irq_sense_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk       (clk),
        .clr_all   (clr_all),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .bus_rdata (bus_rdata),
        .ctl       (ctl),
        .codes_q   (codes_q),
        .ena_q     (ena_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        irq_sense_detect #(
            .IDLE_LEVEL (IDLE_LEVEL)
        ) u_det (
            .clk   (clk),
            .clr   (clr_all),
            .pin_s (pin_s[i]),
            .ctl   (ctl[i]),
            .flag  (flags[i]),
            .req   (irq_req[i])
        );
        assign clr_vec[i] = ctl[i].clr;
        assign chg_vec[i] = ctl[i].chg;
    end

endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        hw_stby,
    input logic [NUM_PINS-1:0]         irq_req,
    input logic [NUM_PINS-1:0]         pin_s,
    input logic [NUM_PINS-1:0]         flags,
    input logic [SENSE_W*NUM_PINS-1:0] codes_q,
    input logic [NUM_PINS-1:0]         ena_q,
    input logic [NUM_PINS-1:0]         clr_vec,
    input logic [NUM_PINS-1:0]         chg_vec
);

    logic [NUM_PINS-1:0] lvl_mask;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            lvl_mask[i] = (codes_q[SENSE_W*i +: SENSE_W] == 2'b00);
        end
    end

    // R8: reset and hardware standby leave every register at zero
    a_r8_clear: assert property (@(posedge clk)
        (rst || hw_stby) |=> (codes_q == '0 && flags == '0 && ena_q == '0));

    // R2: level-mode request follows the synchronized low level
    a_r2_level_follows: assert property (@(posedge clk) disable iff (rst || hw_stby)
        ((irq_req ^ ~pin_s) & lvl_mask & ena_q) == '0);

    // R10: edge-mode request is flag gated by enable
    a_r10_edge_req: assert property (@(posedge clk) disable iff (rst || hw_stby)
        ((irq_req ^ (flags & ena_q)) & ~lvl_mask) == '0);

    // R6: a flag only drops through a clear write or a code change
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst || hw_stby)
        1'b1 |=> (($past(flags) & ~$past(clr_vec) & ~$past(chg_vec)) & ~flags) == '0);

    // R9: a pin in level mode never holds a flag
    a_r9_level_no_flag: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (flags & lvl_mask) == '0);

    // R3 R4 R5: a flag appears only after the synchronized pin changed
    a_r3_flag_needs_edge: assert property (@(posedge clk) disable iff (rst || hw_stby)
        1'b1 |=> ((flags & ~$past(flags)) & ~($past(pin_s) ^ $past(pin_s, 2))) == '0);

endmodule

bind irq_sense_unit irq_sense_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hw_stby (hw_stby),
    .irq_req (irq_req),
    .pin_s   (pin_s),
    .flags   (flags),
    .codes_q (codes_q),
    .ena_q   (ena_q),
    .clr_vec (clr_vec),
    .chg_vec (chg_vec)
);

// File: tb/irq_sense_unit_tb.sv
module irq_sense_unit_tb;

    localparam logic [1:0] A_CODES  = 2'd0;
    localparam logic [1:0] A_EVENTS = 2'd1;
    localparam logic [1:0] A_ENABLE = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_stby = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_sense_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .hw_stby   (hw_stby),
        .irq_pin   (irq_pin),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    function automatic logic [15:0] code(input int pin, input logic [1:0] c);
        return 16'(c) << (2 * pin);
    endfunction

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] d;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        check_eq(tag, d, exp);
    endtask

    task automatic clean();
        wr(A_CODES, 16'h0);
        wr(A_ENABLE, 16'h0);
        irq_pin = 8'hFF;
        wait_n(4);
        wr(A_EVENTS, 16'h00FF);
    endtask

    task automatic t_reset();
        expect_reg("R8 codes after reset", A_CODES, 16'h0);
        expect_reg("R8 flags after reset", A_EVENTS, 16'h0);
        expect_reg("R8 enables after reset", A_ENABLE, 16'h0);
        check_eq("R8 requests after reset", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_placement();
        clean();
        wr(A_CODES, 16'hC3A5);
        expect_reg("R1 codes readback", A_CODES, 16'hC3A5);
        wr(A_ENABLE, 16'h005A);
        expect_reg("R7 enable readback", A_ENABLE, 16'h005A);
        wr(A_ENABLE, 16'h0);
        wr(A_CODES, code(7, 2'b10) | code(0, 2'b01));
        wr(A_EVENTS, 16'h00FF);
        irq_pin = 8'h00;
        wait_n(3);
        expect_reg("R1 pin0 field falls, pin7 field waits", A_EVENTS, 16'h0001);
        irq_pin = 8'hFF;
        wait_n(3);
        expect_reg("R1 pin7 field rises", A_EVENTS, 16'h0081);
    endtask

    task automatic t_level();
        clean();
        wr(A_ENABLE, 16'h0008);
        check_eq("R2 idle high no request", {8'h0, irq_req}, 16'h0);
        irq_pin[3] = 1'b0;
        wait_n(1);
        check_eq("R2 not yet after one edge", {8'h0, irq_req}, 16'h0);
        wait_n(1);
        check_eq("R2 request on second edge", {8'h0, irq_req}, 16'h0008);
        expect_reg("R2 no flag in level mode", A_EVENTS, 16'h0);
        irq_pin[3] = 1'b1;
        wait_n(2);
        check_eq("R2 request drops with pin", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_falling();
        clean();
        wr(A_ENABLE, 16'h00FF);
        wr(A_CODES, code(5, 2'b01));
        irq_pin[5] = 1'b0;
        wait_n(2);
        check_eq("R3 no request before third edge", {8'h0, irq_req}, 16'h0);
        wait_n(1);
        check_eq("R3 request on third edge", {8'h0, irq_req}, 16'h0020);
        expect_reg("R3 falling flag", A_EVENTS, 16'h0020);
        wr(A_EVENTS, 16'h0020);
        irq_pin[5] = 1'b1;
        wait_n(3);
        expect_reg("R3 rise ignored in falling mode", A_EVENTS, 16'h0);
    endtask

    task automatic t_rising();
        clean();
        wr(A_ENABLE, 16'h00FF);
        wr(A_CODES, code(4, 2'b10));
        irq_pin[4] = 1'b0;
        wait_n(4);
        expect_reg("R4 fall ignored in rising mode", A_EVENTS, 16'h0);
        irq_pin[4] = 1'b1;
        wait_n(3);
        expect_reg("R4 rising flag", A_EVENTS, 16'h0010);
        check_eq("R4 rising request", {8'h0, irq_req}, 16'h0010);
    endtask

    task automatic t_both();
        clean();
        wr(A_CODES, code(1, 2'b11));
        irq_pin[1] = 1'b0;
        wait_n(3);
        expect_reg("R5 fall sets flag", A_EVENTS, 16'h0002);
        wr(A_EVENTS, 16'h0002);
        expect_reg("R5 cleared", A_EVENTS, 16'h0);
        irq_pin[1] = 1'b1;
        wait_n(3);
        expect_reg("R5 rise sets flag", A_EVENTS, 16'h0002);
    endtask

    task automatic t_sticky();
        clean();
        wr(A_CODES, code(2, 2'b01));
        irq_pin[2] = 1'b0;
        wait_n(3);
        irq_pin[2] = 1'b1;
        wait_n(4);
        expect_reg("R6 flag held after pin returns", A_EVENTS, 16'h0004);
        wr(A_EVENTS, 16'h0009);
        expect_reg("R6 other bits do not clear", A_EVENTS, 16'h0004);
        wr(A_EVENTS, 16'h0004);
        expect_reg("R6 write one clears", A_EVENTS, 16'h0);
        irq_pin[2] = 1'b0;
        wait_n(2);
        wr(A_EVENTS, 16'h0004);
        expect_reg("R6 event beats same-cycle clear", A_EVENTS, 16'h0004);
    endtask

    task automatic t_enable();
        clean();
        wr(A_CODES, code(0, 2'b10));
        irq_pin[0] = 1'b0;
        wait_n(4);
        wr(A_EVENTS, 16'h00FF);
        irq_pin[0] = 1'b1;
        wait_n(3);
        expect_reg("R7 flag records while disabled", A_EVENTS, 16'h0001);
        check_eq("R7 disabled request low", {8'h0, irq_req}, 16'h0);
        wr(A_ENABLE, 16'h0001);
        check_eq("R10 request follows enable", {8'h0, irq_req}, 16'h0001);
        wr(A_ENABLE, 16'h0000);
        check_eq("R7 request drops on disable", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_mode_change();
        clean();
        wr(A_CODES, code(4, 2'b01));
        irq_pin[4] = 1'b0;
        wait_n(3);
        expect_reg("R9 setup flag", A_EVENTS, 16'h0010);
        wr(A_CODES, code(4, 2'b10));
        expect_reg("R9 code change clears flag", A_EVENTS, 16'h0);
        wr(A_CODES, 16'h0);
        irq_pin[6] = 1'b0;
        wait_n(4);
        wr(A_EVENTS, 16'h00FF);
        irq_pin[6] = 1'b1;
        wait_n(1);
        wr(A_CODES, code(6, 2'b10));
        wait_n(2);
        expect_reg("R9 in-flight edge dropped", A_EVENTS, 16'h0);
        irq_pin[6] = 1'b0;
        wait_n(4);
        irq_pin[6] = 1'b1;
        wait_n(3);
        expect_reg("R9 later edge detected", A_EVENTS, 16'h0040);
    endtask

    task automatic t_hw_stby();
        clean();
        wr(A_CODES, 16'hFFFF);
        wr(A_ENABLE, 16'h00FF);
        irq_pin[0] = 1'b0;
        wait_n(3);
        expect_reg("R8 setup flag", A_EVENTS, 16'h0001);
        hw_stby = 1'b1;
        wait_n(1);
        wr(A_CODES, 16'h1234);
        hw_stby = 1'b0;
        expect_reg("R8 standby clears codes", A_CODES, 16'h0);
        expect_reg("R8 standby clears enables", A_ENABLE, 16'h0);
        expect_reg("R8 standby clears flags", A_EVENTS, 16'h0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_placement();
        t_level();
        t_falling();
        t_rising();
        t_both();
        t_sticky();
        t_enable();
        t_mode_change();
        t_hw_stby();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule